// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a host I/O bus and gives software two small windows for reaching configuration space. The first window, four byte ports starting at 0x0CF8, holds a 32-bit selector. The selector names a bus, a device, a function and a dword register. The second window, four byte ports starting at 0x0CFC, is the data path. An access there becomes a sequence of single-byte reads or writes on a downstream configuration-space port, aimed at the device and function the selector names.

Before it issues any downstream traffic, the block checks a presence bitmap indexed by the device/function key. Only bus 0 is served. A read aimed at another bus or at an absent function completes at once with all-ones in the requested bytes, and a write to either is discarded. Each access ends with a one-cycle done pulse, or with a one-cycle error pulse when its length and lane offset break the alignment rules.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector register is zero, and io_done, io_err and cfg_req are low.
- R2: Only I/O addresses 0x0CF8..0x0CFB (selector) and 0x0CFC..0x0CFF (data window) are claimed. An access to any other address gives no done, no error and no downstream request.
- R3: Legal accesses are: io_len=4 at lane 0, io_len=2 at lanes 0..2, and io_len=1 at any lane, where the lane is io_addr[1:0]. Any other length or lane, in either window, makes io_err pulse for one cycle, one cycle after the request. It gives no done, issues no downstream request and leaves the selector unchanged.
- R4: A legal selector write replaces only the addressed bytes. Request byte k lands in selector byte lane+k. A selector read returns selector bytes lane..lane+len-1 in io_rdata bytes 0..len-1, with the upper bytes zero. Both complete with io_done one cycle after the request.
- R5: The selector fields are bus [23:16], device [15:11], function [10:8] and dword [7:2]. The downstream key is {device,function} (device<<3 | function). The byte offset is dword*4 + io_addr[1:0], carried as cfg_dword plus a one-hot cfg_be lane.
- R6: A data-window read with a non-zero bus field, or whose key has dev_present low, returns 0xFF in each requested byte and zero above them. It issues no downstream request and gives io_done one cycle after the request.
- R7: A data-window write with a non-zero bus field, or to an absent key, is dropped. It issues no downstream request and gives io_done one cycle after the request.
- R8: An accepted access to a present key on bus 0 issues exactly io_len downstream byte requests on consecutive cycles, starting in the cycle after the request. They run from the lowest byte upward, so cfg_be shifts left by one each cycle. io_done follows the last one by one cycle. A new io_req while the sequence runs is ignored.
- R9: A sequenced read returns the byte fetched for request byte k in io_rdata byte k, with the upper bytes zero. A sequenced write drives request byte k of io_wdata on cfg_wdata.
- R10: io_done and io_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Host access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O byte address |
| io_len | input | 3 | Access length in bytes (1, 2 or 4 legal) |
| io_wdata | input | 32 | Write data, byte 0 first |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_done | output | 1 | Access completed (one cycle) |
| io_err | output | 1 | Access rejected (one cycle) |
| dev_present | input | 256 | Presence bit per device/function key |
| cfg_req | output | 1 | Downstream byte request |
| cfg_we | output | 1 | Downstream request is a write |
| cfg_key | output | 8 | Target {device,function} |
| cfg_dword | output | 6 | Target dword register |
| cfg_be | output | 4 | One-hot byte lane within the dword |
| cfg_wdata | output | 8 | Downstream write byte |
| cfg_rdata | input | 8 | Downstream read byte, same cycle as cfg_req |

## Verification
Assertions check on every cycle the behaviour that can be stated locally in time. A rejected request leaves the selector unchanged and yields an error without done. Unclaimed addresses stay silent. Requests to another bus start no downstream traffic. Byte requests advance one lane per cycle from the start lane and stop after the last one. Done and error never coincide. Only the bench scenarios can show that the bytes land where they should and that the results are right: selector contents after partial writes, the offset and key reaching the right stored bytes, the ordering of assembled read data, the all-ones fill for absent targets, and the dropping of a request made while a sequence is running.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int DW       = 32;
  localparam int NB       = DW / 8;
  localparam int BUS_LSB  = 16;
  localparam int BUS_W    = 8;
  localparam int DEV_LSB  = 11;
  localparam int DEV_W    = 5;
  localparam int FN_LSB   = 8;
  localparam int FN_W     = 3;
  localparam int REG_LSB  = 2;
  localparam int REG_W    = 6;
  localparam int KEY_W    = DEV_W + FN_W;
  localparam int NUM_KEYS = 1 << KEY_W;

  typedef enum logic [1:0] {TGT_NONE, TGT_ADDR, TGT_DATA} tgt_e;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // Legal length/lane pairs for both windows.
  function automatic logic lane_ok(input logic [1:0] lane, input logic [2:0] len);
    case (len)
      3'd4:    lane_ok = (lane == 2'd0);
      3'd2:    lane_ok = (lane != 2'd3);
      3'd1:    lane_ok = 1'b1;
      default: lane_ok = 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] len_mask(input logic [2:0] len);
    case (len)
      3'd1:    len_mask = 32'h0000_00FF;
      3'd2:    len_mask = 32'h0000_FFFF;
      3'd3:    len_mask = 32'h00FF_FFFF;
      default: len_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgdec_port_match.sv
module cfgdec_port_match
  import cfgdec_pkg::*;
#(
  parameter int                IO_AW     = 16,
  parameter logic [IO_AW-1:0]  ADDR_BASE = 16'h0CF8,
  parameter logic [IO_AW-1:0]  DATA_BASE = 16'h0CFC
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic [2:0]       io_len,
  output tgt_e             tgt,
  output logic [1:0]       lane,
  output logic             legal
);

  localparam int PAGE_W = IO_AW - 2;
  localparam logic [PAGE_W-1:0] ADDR_PAGE = ADDR_BASE[IO_AW-1:2];
  localparam logic [PAGE_W-1:0] DATA_PAGE = DATA_BASE[IO_AW-1:2];

  logic [PAGE_W-1:0] page;

  assign page = io_addr[IO_AW-1:2];
  assign lane = io_addr[1:0];

  always_comb begin
    if (page == ADDR_PAGE)      tgt = TGT_ADDR;
    else if (page == DATA_PAGE) tgt = TGT_DATA;
    else                        tgt = TGT_NONE;
  end

  assign legal = lane_ok(lane, io_len);

endmodule

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg
  import cfgdec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    lane,
  input  logic [2:0]    len,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] wshift;
  logic [4:0]    lane_sh;
  logic [7:0]    byte_d [NB];
  logic [DW-1:0] q_d;

  assign lane_sh = {lane, 3'b000};
  assign wshift  = wdata << lane_sh;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic hit;
    assign hit = wr_en && (3'(b) >= {1'b0, lane}) && (3'(b) < ({1'b0, lane} + len));
    always_comb begin
      byte_d[b] = q[8*b +: 8];
      if (hit) byte_d[b] = wshift[8*b +: 8];
    end
    assign q_d[8*b +: 8] = byte_d[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end

  assign rdata = (q >> lane_sh) & len_mask(len);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> q == $past(q))
    else $error("selector changed without a write");

endmodule

// File: rtl/cfgdec_seq.sv
module cfgdec_seq
  import cfgdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_we,
  input  logic [1:0]       start_lane,
  input  logic [2:0]       start_len,
  input  logic [DW-1:0]    start_wdata,
  input  logic [KEY_W-1:0] start_key,
  input  logic [REG_W-1:0] start_dw,
  input  logic [7:0]       cfg_rdata,
  output logic             busy,
  output logic             last,
  output logic [DW-1:0]    acc_next,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [KEY_W-1:0] cfg_key,
  output logic [REG_W-1:0] cfg_dword,
  output logic [NB-1:0]    cfg_be,
  output logic [7:0]       cfg_wdata
);

  seq_state_e       state_q, state_d;
  logic [2:0]       idx_q, idx_d;
  logic [2:0]       len_q, len_d;
  logic [1:0]       lane_q, lane_d;
  logic             we_q, we_d;
  logic [DW-1:0]    wd_q, wd_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [REG_W-1:0] dw_q, dw_d;
  logic [DW-1:0]    acc_q, acc_d;
  logic             load;

  logic [1:0] cur_lane;
  logic [5:0] bsh;

  assign cur_lane  = lane_q + idx_q[1:0];
  assign bsh       = {idx_q, 3'b000};
  assign busy      = (state_q == SEQ_RUN);
  assign cfg_req   = busy;
  assign cfg_we    = we_q;
  assign cfg_key   = key_q;
  assign cfg_dword = dw_q;
  assign cfg_be    = NB'(1) << cur_lane;
  assign cfg_wdata = 8'(wd_q >> bsh);
  assign last      = busy && ((idx_q + 3'd1) == len_q);
  assign acc_next  = acc_q | (we_q ? '0 : (DW'(cfg_rdata) << bsh));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    load    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
          acc_d   = '0;
          load    = 1'b1;
        end
      end
      SEQ_RUN: begin
        idx_d = idx_q + 3'd1;
        acc_d = acc_next;
        if (last) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign len_d  = load ? start_len   : len_q;
  assign lane_d = load ? start_lane  : lane_q;
  assign we_d   = load ? start_we    : we_q;
  assign wd_d   = load ? start_wdata : wd_q;
  assign key_d  = load ? start_key   : key_q;
  assign dw_d   = load ? start_dw    : dw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      lane_q  <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      key_q   <= '0;
      dw_q    <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      lane_q  <= lane_d;
      we_q    <= we_d;
      wd_q    <= wd_d;
      key_q   <= key_d;
      dw_q    <= dw_d;
      acc_q   <= acc_d;
    end
  end

  p_first_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cfg_req && (cfg_be == (NB'(1) << $past(start_lane))))
    else $error("first byte request on wrong lane");

  p_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !last |=> cfg_req && (cfg_be == ($past(cfg_be) << 1)))
    else $error("byte requests not consecutive or not ascending");

  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !cfg_req)
    else $error("byte request after the last byte");

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start)
    else $error("sequence restarted while running");

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter int               IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_BASE = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_BASE = 16'h0CFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_req,
  input  logic                io_we,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic [2:0]          io_len,
  input  logic [DW-1:0]       io_wdata,
  output logic [DW-1:0]       io_rdata,
  output logic                io_done,
  output logic                io_err,
  input  logic [NUM_KEYS-1:0] dev_present,
  output logic                cfg_req,
  output logic                cfg_we,
  output logic [KEY_W-1:0]    cfg_key,
  output logic [REG_W-1:0]    cfg_dword,
  output logic [NB-1:0]       cfg_be,
  output logic [7:0]          cfg_wdata,
  input  logic [7:0]          cfg_rdata
);

  tgt_e          tgt;
  logic [1:0]    lane;
  logic          legal;
  logic [DW-1:0] sel_q, sel_rdata;
  logic          seq_busy, seq_last;
  logic [DW-1:0] seq_acc;

  logic              accept, take_addr, take_data, bad, sel_wr, seq_start;
  logic [BUS_W-1:0]  f_bus;
  logic [KEY_W-1:0]  f_key;
  logic [REG_W-1:0]  f_dw;
  logic              hit;

  logic          done_q, done_d;
  logic          err_q, err_d;
  logic [DW-1:0] rd_q, rd_d;

  cfgdec_port_match #(
    .IO_AW     (IO_AW),
    .ADDR_BASE (ADDR_BASE),
    .DATA_BASE (DATA_BASE)
  ) u_match (
    .io_addr (io_addr),
    .io_len  (io_len),
    .tgt     (tgt),
    .lane    (lane),
    .legal   (legal)
  );

  assign accept    = io_req && !seq_busy;
  assign bad       = accept && (tgt != TGT_NONE) && !legal;
  assign take_addr = accept && (tgt == TGT_ADDR) && legal;
  assign take_data = accept && (tgt == TGT_DATA) && legal;
  assign sel_wr    = take_addr && io_we;

  assign f_bus = sel_q[BUS_LSB +: BUS_W];
  assign f_key = {sel_q[DEV_LSB +: DEV_W], sel_q[FN_LSB +: FN_W]};
  assign f_dw  = sel_q[REG_LSB +: REG_W];
  assign hit   = dev_present[f_key];

  assign seq_start = take_data && (f_bus == '0) && hit;

  cfgdec_addr_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (sel_wr),
    .lane  (lane),
    .len   (io_len),
    .wdata (io_wdata),
    .q     (sel_q),
    .rdata (sel_rdata)
  );

  cfgdec_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (seq_start),
    .start_we    (io_we),
    .start_lane  (lane),
    .start_len   (io_len),
    .start_wdata (io_wdata),
    .start_key   (f_key),
    .start_dw    (f_dw),
    .cfg_rdata   (cfg_rdata),
    .busy        (seq_busy),
    .last        (seq_last),
    .acc_next    (seq_acc),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_key     (cfg_key),
    .cfg_dword   (cfg_dword),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata)
  );

  // Response next-state
  always_comb begin
    done_d = 1'b0;
    err_d  = 1'b0;
    rd_d   = rd_q;
    if (bad) begin
      err_d = 1'b1;
    end else if (take_addr) begin
      done_d = 1'b1;
      rd_d   = io_we ? '0 : sel_rdata;
    end else if (take_data && !seq_start) begin
      done_d = 1'b1;
      rd_d   = io_we ? '0 : len_mask(io_len);
    end else if (seq_last) begin
      done_d = 1'b1;
      rd_d   = seq_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      if (done_d) rd_q <= rd_d;
    end
  end

  assign io_done  = done_q;
  assign io_err   = err_q;
  assign io_rdata = rd_q;

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |-> !io_err)
    else $error("done and error together");

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !seq_busy && (tgt != TGT_NONE) && !legal
      |=> io_err && !io_done && !cfg_req && (sel_q == $past(sel_q)))
    else $error("illegal access not rejected cleanly");

  p_unclaimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !seq_busy && (tgt == TGT_NONE) |=> !io_done && !io_err && !cfg_req)
    else $error("unclaimed address produced a response");

  p_other_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !seq_busy && (tgt == TGT_DATA) && (f_bus != '0) |=> !cfg_req)
    else $error("downstream request for a non-zero bus");

endmodule

// File: tb/cfg_port_decoder_bench.sv
`timescale 1ns/1ps
module cfg_port_decoder_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         io_req, io_we;
  logic [15:0]  io_addr;
  logic [2:0]   io_len;
  logic [31:0]  io_wdata, io_rdata;
  logic         io_done, io_err;
  logic [255:0] dev_present;
  logic         cfg_req, cfg_we;
  logic [7:0]   cfg_key;
  logic [5:0]   cfg_dword;
  logic [3:0]   cfg_be;
  logic [7:0]   cfg_wdata, cfg_rdata;

  always #2.5 clk = ~clk;

  cfg_port_decoder u_cfg_port_decoder (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_len(io_len), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_done(io_done),
    .io_err(io_err), .dev_present(dev_present), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_key(cfg_key), .cfg_dword(cfg_dword), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Downstream config space environment and request log
  logic [7:0] env_mem [65536];
  int         req_cnt = 0;
  logic [3:0] log_be  [1024];
  logic [7:0] log_key [1024];
  logic [5:0] log_dw  [1024];
  logic       log_we  [1024];
  logic [7:0] log_wd  [1024];

  function automatic logic [7:0] init_byte(input int i);
    logic [15:0] a;
    a = 16'(i);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h3C;
  endfunction

  function automatic int be2lane(input logic [3:0] be);
    case (be)
      4'b0010: return 1;
      4'b0100: return 2;
      4'b1000: return 3;
      default: return 0;
    endcase
  endfunction

  always_comb cfg_rdata = env_mem[{cfg_key, cfg_dword, 2'(be2lane(cfg_be))}];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 65536; i++) env_mem[i] = init_byte(i);
    end else if (cfg_req) begin
      log_be[req_cnt % 1024]  = cfg_be;
      log_key[req_cnt % 1024] = cfg_key;
      log_dw[req_cnt % 1024]  = cfg_dword;
      log_we[req_cnt % 1024]  = cfg_we;
      log_wd[req_cnt % 1024]  = cfg_wdata;
      if (cfg_we) env_mem[{cfg_key, cfg_dword, 2'(be2lane(cfg_be))}] = cfg_wdata;
      req_cnt = req_cnt + 1;
    end
  end

  // Bench model
  logic [31:0] m_sel;
  logic [7:0]  exp_mem [65536];

  function automatic bit legal_m(input logic [1:0] off, input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2 && off <= 2'd2) || (len == 3'd4 && off == 2'd0);
  endfunction

  function automatic logic [31:0] ones(input logic [2:0] len);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) if (k < int'(len)) v[8*k +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One host access with full expectation check
  task automatic access(input bit we, input logic [15:0] a, input logic [2:0] len, input logic [31:0] wd);
    logic [1:0]  off;
    bit          is_sel, is_dat, ok, present, seq;
    logic [31:0] exp_rd, got_rd;
    bit          got_dn, got_er;
    int          c0, nreq;
    logic [7:0]  key;
    logic [5:0]  dw;
    off    = a[1:0];
    is_sel = (a[15:2] == 14'h033E);
    is_dat = (a[15:2] == 14'h033F);
    ok     = legal_m(off, len);
    key    = {m_sel[15:11], m_sel[10:8]};
    dw     = m_sel[7:2];
    present = dev_present[key] && (m_sel[23:16] == 8'h00);
    seq    = is_dat && ok && present;
    c0     = req_cnt;
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_len = len; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    got_dn = 0; got_er = 0; got_rd = '0;
    for (int k = 0; k < 8; k++) begin
      if (io_done || io_err) begin
        got_dn = io_done; got_er = io_err; got_rd = io_rdata;
        if (seq) check("R8", "done latency", 32'(k), 32'(len));
        else     check("R3", "response latency", 32'(k), 32'd0);
        check("R10", "done with err", 32'(io_done & io_err), 32'd0);
        @(negedge clk);
        check("R10", "pulse width", {30'd0, io_done, io_err}, 32'd0);
        break;
      end
      @(negedge clk);
    end
    nreq = req_cnt - c0;
    if (!is_sel && !is_dat) begin
      check("R2", "unclaimed done/err", {30'd0, got_dn, got_er}, 32'd0);
      check("R2", "unclaimed requests", 32'(nreq), 32'd0);
    end else if (!ok) begin
      check("R3", "reject done/err", {30'd0, got_dn, got_er}, 32'b01);
      check("R3", "reject requests", 32'(nreq), 32'd0);
    end else if (is_sel) begin
      check("R4", "selector done/err", {30'd0, got_dn, got_er}, 32'b10);
      if (we) begin
        for (int k = 0; k < 4; k++)
          if (k >= int'(off) && k < int'(off) + int'(len))
            m_sel[8*k +: 8] = wd[8*(k-int'(off)) +: 8];
      end else begin
        check("R4", "selector read", got_rd, (m_sel >> (8*off)) & ones(len));
      end
    end else begin
      check("R6", "data done/err", {30'd0, got_dn, got_er}, 32'b10);
      if (!seq) begin
        check("R7", "dropped access requests", 32'(nreq), 32'd0);
        if (!we) check("R6", "absent read fill", got_rd, ones(len));
      end else begin
        check("R8", "request count", 32'(nreq), 32'(len));
        exp_rd = '0;
        for (int k = 0; k < int'(len) && k < nreq; k++) begin
          int j;
          j = (c0 + k) % 1024;
          check("R8", "byte enable order", {28'd0, log_be[j]}, 32'(4'b0001 << (int'(off) + k)));
          check("R5", "key/dword", {18'd0, log_key[j], log_dw[j]}, {18'd0, key, dw});
          check("R8", "request direction", 32'(log_we[j]), 32'(we));
          if (we) begin
            check("R9", "write byte", 32'(log_wd[j]), 32'(wd[8*k +: 8]));
            exp_mem[{key, dw, 2'(int'(off) + k)}] = wd[8*k +: 8];
          end else begin
            exp_rd[8*k +: 8] = exp_mem[{key, dw, 2'(int'(off) + k)}];
          end
        end
        if (!we) check("R9", "assembled read", got_rd, exp_rd);
      end
    end
  endtask

  function automatic logic [31:0] mk_sel(input logic [7:0] bus, input logic [4:0] dev,
                                         input logic [2:0] fn, input logic [5:0] r);
    return {8'h80, bus, dev, fn, r, 2'b00};
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    logic [2:0] lens [3];
    lens[0] = 3'd1; lens[1] = 3'd2; lens[2] = 3'd4;
    unused_seed = $urandom(32'd20240611);
    io_req = 0; io_we = 0; io_addr = '0; io_len = 3'd4; io_wdata = '0;
    for (int i = 0; i < 8; i++) dev_present[32*i +: 32] = $urandom;
    dev_present[8'h08] = 1'b1;
    dev_present[8'h10] = 1'b0;
    dev_present[8'h11] = 1'b1;
    for (int i = 0; i < 65536; i++) exp_mem[i] = init_byte(i);
    m_sel = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done/err/cfg_req", {29'd0, io_done, io_err, cfg_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 16'h0CF8, 3'd4, 0);                        // R1 selector reads zero
    // R3 illegal shapes
    access(1, 16'h0CF9, 3'd4, 32'hDEADBEEF);
    access(1, 16'h0CFB, 3'd2, 32'hDEADBEEF);
    access(1, 16'h0CF8, 3'd3, 32'hDEADBEEF);
    access(1, 16'h0CF8, 3'd0, 32'hDEADBEEF);
    access(0, 16'h0CFD, 3'd4, 0);
    access(0, 16'h0CF8, 3'd4, 0);
    // R2 unclaimed
    access(1, 16'h0CF7, 3'd1, 32'h55);
    access(0, 16'h0D00, 3'd4, 0);
    // R4 partial selector writes
    access(1, 16'h0CF8, 3'd4, mk_sel(8'h00, 5'd1, 3'd0, 6'd3));
    access(1, 16'h0CFA, 3'd2, 32'h0000_8055);
    access(1, 16'h0CF9, 3'd1, 32'h0000_0009);
    access(0, 16'h0CF9, 3'd2, 0);
    access(0, 16'h0CFB, 3'd1, 0);
    // R5/R8/R9 present key 0x08
    access(1, 16'h0CF8, 3'd4, mk_sel(8'h00, 5'd1, 3'd0, 6'd5));
    access(0, 16'h0CFC, 3'd4, 0);
    access(1, 16'h0CFD, 3'd2, 32'h0000_A1B2);
    access(0, 16'h0CFC, 3'd4, 0);
    access(1, 16'h0CFF, 3'd1, 32'h0000_00C7);
    access(0, 16'h0CFE, 3'd2, 0);
    // R6/R7 absent key 0x10
    access(1, 16'h0CF8, 3'd4, mk_sel(8'h00, 5'd2, 3'd0, 6'd1));
    access(0, 16'h0CFC, 3'd4, 0);
    access(1, 16'h0CFC, 3'd4, 32'h1234_5678);
    access(0, 16'h0CFE, 3'd2, 0);
    // R6/R7 non-zero bus with a present key
    access(1, 16'h0CF8, 3'd4, mk_sel(8'h01, 5'd1, 3'd0, 6'd5));
    access(0, 16'h0CFD, 3'd1, 0);
    access(1, 16'h0CFC, 3'd4, 32'hFFFF_0000);
    access(1, 16'h0CFA, 3'd1, 32'h0000_0000);            // back to bus 0
    access(0, 16'h0CFC, 3'd4, 0);                         // R7 nothing was written
    // R8 request during a running sequence is ignored
    @(negedge clk);
    io_req = 1; io_we = 0; io_addr = 16'h0CFC; io_len = 3'd4;
    @(negedge clk);
    io_addr = 16'h0CF8; io_we = 1; io_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    io_req = 0;
    repeat (6) @(negedge clk);
    access(0, 16'h0CF8, 3'd4, 0);
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [2:0] ln;
      logic [1:0] of;
      op = $urandom % 8;
      ln = lens[$urandom % 3];
      of = 2'($urandom);
      if ($urandom % 10 == 0) ln = 3'($urandom);
      case (op)
        0: access(1, 16'h0CF8, 3'd4,
                  mk_sel(($urandom % 4 == 0) ? 8'($urandom) : 8'h00,
                         5'($urandom), 3'($urandom % 2), 6'($urandom)));
        1, 2: access(1, {14'h033E, of}, ln, $urandom);
        3: access(0, {14'h033E, of}, ln, 0);
        4, 5: access(0, {14'h033F, of}, ln, 0);
        6: access(1, {14'h033F, of}, ln, $urandom);
        default: access($urandom % 2 == 1, 16'($urandom), ln, $urandom);
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule